// File: doc/BRIEF.md
# Dual Shift-Register Dither Generator

This block supplies a pseudo-random dither bit for an in-phase (I) path and a quadrature (Q) path on every clock. The bits are meant to be added to the output of a digital mixer. Two maximal-length linear-feedback shift registers run side by side. One is 23 bits long and repeats every 2^23-1 steps. The other is 15 bits long and repeats every 2^15-1 steps. Each register has its own enable. When both run, their output bits are XORed, so the combined sequence repeats far less often than either one alone.

A decorrelation option breaks the symmetry between the two paths. With the option set, the I bit is XORed with one stage of the long register, so I no longer copies Q. With the option clear, both paths carry the same bit. Adding the dither to the mixer samples is done outside this block, and so is the decoding of the control word that drives the enables.

Top module: `dither_pn_gen`

## Requirements
- R1: A synchronous active-low reset clears `dith_i`, `dith_q` and `dith_valid` to 0 and loads both shift registers with all ones. The first step after reset therefore starts from the all-ones state, and no register is ever all zeros.
- R2: The long generator is a 23-bit Fibonacci register with feedback polynomial x^23+x^18+1. On each enabled clock it shifts toward the MSB. The new LSB is the XOR of state bit 22 and state bit 17. Its output bit is state bit 22.
- R3: The short generator is a 15-bit Fibonacci register with feedback polynomial x^15+x^14+1. It shifts the same way, with the new LSB taken as the XOR of state bits 14 and 13, and its output bit is state bit 14. Run alone, its output repeats with a period of 32767 clocks.
- R4: A generator whose enable is low keeps its state, and its output counts as 0 in the combination. When it is enabled again, it resumes from the held state.
- R5: When both generators are enabled, the dither bit is the XOR of the two output bits.
- R6: With `i_offset_en` low, `dith_i` equals `dith_q` on every cycle.
- R7: With `i_offset_en` high and at least one generator enabled, `dith_i` equals `dith_q` XOR bit 10 of the long register's state.
- R8: `dith_valid` is high exactly when at least one enable was high. When neither enable is high, both dither bits are 0.
- R9: The outputs are registered. The bits seen after a clock edge are computed from the enables sampled at that edge and from the register states held before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_long | input | 1 | Enable for the 23-bit generator |
| en_short | input | 1 | Enable for the 15-bit generator |
| i_offset_en | input | 1 | Offsets the I bit by long-register stage 10 |
| dith_i | output | 1 | Dither bit for the in-phase path |
| dith_q | output | 1 | Dither bit for the quadrature path |
| dith_valid | output | 1 | High when the dither bits come from at least one running generator |

## Verification
The short generator runs alone for a full period, and its output is then compared with its first bits. A wrong tap would show up either as a stream that fails to match the reference model or as a period other than 32767. The enables are toggled in irregular patterns to expose a generator that keeps stepping while disabled, or that leaks its bit into the XOR while off. The result would be a permanent phase slip against the model. Runs with the offset option on and off catch an I bit that ignores the option, reads the wrong stage, or stays active when both generators are idle. A reset in the middle of a run checks that the registers reload with all ones and do not simply freeze.

// File: rtl/dither_pkg.sv
package dither_pkg;

    // Feedback positions, given as 1-based polynomial exponents.
    localparam int unsigned LONG_LEN_DEF  = 23;
    localparam int unsigned LONG_TAP_DEF  = 18;
    localparam int unsigned SHORT_LEN_DEF = 15;
    localparam int unsigned SHORT_TAP_DEF = 14;
    localparam int unsigned OFS_BIT_DEF   = 10;

    typedef struct packed {
        logic bit_i;
        logic bit_q;
        logic valid;
    } dith_word_t;

endpackage

// File: rtl/dither_lfsr.sv
// Fibonacci shift register: shifts toward the MSB and feeds the
// XOR of two stages back into the LSB. The state holds while disabled.
module dither_lfsr #(
    parameter int unsigned LEN   = 23,
    parameter int unsigned TAP_A = 23,
    parameter int unsigned TAP_B = 18
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_en,
    output logic [LEN-1:0] state
);
    localparam int unsigned IA = TAP_A - 1;
    localparam int unsigned IB = TAP_B - 1;

    typedef struct packed {
        logic [LEN-1:0] sr;
    } lfsr_reg_t;

    lfsr_reg_t reg_d, reg_q;
    logic      fb_bit;

    always_comb begin
        fb_bit = reg_q.sr[IA] ^ reg_q.sr[IB];
        reg_d  = reg_q;
        if (step_en) begin
            reg_d.sr = {reg_q.sr[LEN-2:0], fb_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q.sr <= '1;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign state = reg_q.sr;
endmodule

// File: rtl/dither_mix.sv
// Combines the selected generator bits into the I and Q dither values.
module dither_mix #(
    parameter bit USE_OFFSET = 1'b1
) (
    input  logic long_msb,
    input  logic short_msb,
    input  logic long_tap,
    input  logic en_long,
    input  logic en_short,
    input  logic ofs_en,
    output logic mix_i,
    output logic mix_q,
    output logic any_en
);
    logic long_part, short_part, base;

    always_comb begin
        long_part  = en_long  & long_msb;
        short_part = en_short & short_msb;
        base       = long_part ^ short_part;
        any_en     = en_long | en_short;
        mix_q      = base;
    end

    generate
        if (USE_OFFSET) begin : g_ofs
            always_comb mix_i = base ^ (ofs_en & any_en & long_tap);
        end else begin : g_no_ofs
            logic unused_ofs;
            always_comb begin
                unused_ofs = ofs_en ^ long_tap;
                mix_i      = base;
            end
        end
    endgenerate
endmodule

// File: rtl/dither_pn_gen.sv
module dither_pn_gen
    import dither_pkg::*;
#(
    parameter int unsigned LONG_LEN  = LONG_LEN_DEF,
    parameter int unsigned LONG_TAP  = LONG_TAP_DEF,
    parameter int unsigned SHORT_LEN = SHORT_LEN_DEF,
    parameter int unsigned SHORT_TAP = SHORT_TAP_DEF,
    parameter int unsigned OFS_BIT   = OFS_BIT_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_long,
    input  logic en_short,
    input  logic i_offset_en,
    output logic dith_i,
    output logic dith_q,
    output logic dith_valid
);
    localparam bit OFS_OK = (OFS_BIT < LONG_LEN);

    logic [LONG_LEN-1:0]  long_state;
    logic [SHORT_LEN-1:0] short_state;
    logic mix_i, mix_q, any_en, ofs_tap;

    dither_lfsr #(.LEN(LONG_LEN), .TAP_A(LONG_LEN), .TAP_B(LONG_TAP)) u_long (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (en_long),
        .state   (long_state)
    );

    dither_lfsr #(.LEN(SHORT_LEN), .TAP_A(SHORT_LEN), .TAP_B(SHORT_TAP)) u_short (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (en_short),
        .state   (short_state)
    );

    generate
        if (OFS_OK) begin : g_tap
            assign ofs_tap = long_state[OFS_BIT];
        end else begin : g_no_tap
            assign ofs_tap = 1'b0;
        end
    endgenerate

    dither_mix #(.USE_OFFSET(OFS_OK)) u_mix (
        .long_msb  (long_state[LONG_LEN-1]),
        .short_msb (short_state[SHORT_LEN-1]),
        .long_tap  (ofs_tap),
        .en_long   (en_long),
        .en_short  (en_short),
        .ofs_en    (i_offset_en),
        .mix_i     (mix_i),
        .mix_q     (mix_q),
        .any_en    (any_en)
    );

    dith_word_t out_d, out_q;

    always_comb begin
        out_d.bit_i = mix_i;
        out_d.bit_q = mix_q;
        out_d.valid = any_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dith_i     = out_q.bit_i;
    assign dith_q     = out_q.bit_q;
    assign dith_valid = out_q.valid;
endmodule

// File: rtl/dither_pn_chk.sv
module dither_pn_chk #(
    parameter int unsigned LONG_LEN  = 23,
    parameter int unsigned SHORT_LEN = 15
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en_long,
    input logic                 en_short,
    input logic                 i_offset_en,
    input logic                 dith_i,
    input logic                 dith_q,
    input logic                 dith_valid,
    input logic [LONG_LEN-1:0]  long_state,
    input logic [SHORT_LEN-1:0] short_state
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!dith_i && !dith_q && !dith_valid)); // R1

    AST_LONG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        long_state != '0); // R1

    AST_SHORT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        short_state != '0); // R1

    AST_LONG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_long |=> $stable(long_state)); // R4

    AST_SHORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_short |=> $stable(short_state)); // R4

    AST_IQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !i_offset_en |=> (dith_i == dith_q)); // R6

    AST_VALID_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (en_long || en_short) |=> dith_valid); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_long && !en_short) |=> (!dith_valid && !dith_i && !dith_q)); // R8
endmodule

bind dither_pn_gen dither_pn_chk #(
    .LONG_LEN  (LONG_LEN),
    .SHORT_LEN (SHORT_LEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_long     (en_long),
    .en_short    (en_short),
    .i_offset_en (i_offset_en),
    .dith_i      (dith_i),
    .dith_q      (dith_q),
    .dith_valid  (dith_valid),
    .long_state  (long_state),
    .short_state (short_state)
);

// File: tb/dither_pn_gen_bench.sv
`timescale 1ns/1ps
module dither_pn_gen_bench;
    localparam int SHORT_PERIOD = 32767;
    localparam int CAP = 40;

    typedef struct {
        bit    ei;
        bit    eq;
        bit    ev;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_long = 1'b0, en_short = 1'b0, i_offset_en = 1'b0;
    logic dith_i, dith_q, dith_valid;

    int checks = 0;
    int fails  = 0;
    exp_t sb_q[$];

    bit [22:0] m_long  = '1;
    bit [14:0] m_short = '1;

    bit cap_first[CAP];
    int short_idx = 0;
    int ofs_diffs = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dither_pn_gen u_dither_pn_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_long     (en_long),
        .en_short    (en_short),
        .i_offset_en (i_offset_en),
        .dith_i      (dith_i),
        .dith_q      (dith_q),
        .dith_valid  (dith_valid)
    );

    function automatic bit [22:0] long_next(bit [22:0] s);
        return {s[21:0], s[22] ^ s[17]};
    endfunction

    function automatic bit [14:0] short_next(bit [14:0] s);
        return {s[13:0], s[14] ^ s[13]};
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp_v);
        end
    endtask

    // Driver: applies one cycle of stimulus and records the expected outputs.
    task automatic drive(bit el, bit es, bit ofs, string tag);
        exp_t e;
        bit lb, sb, base, any;
        @(negedge clk);
        rst_n       = 1'b1;
        en_long     = el;
        en_short    = es;
        i_offset_en = ofs;
        lb   = el & m_long[22];
        sb   = es & m_short[14];
        base = lb ^ sb;
        any  = el | es;
        e.eq  = base;
        e.ei  = any ? (base ^ (ofs & m_long[10])) : 1'b0;
        e.ev  = any;
        e.tag = tag;
        sb_q.push_back(e);
        if (el) m_long = long_next(m_long);
        if (es) m_short = short_next(m_short);
    endtask

    task automatic do_reset(int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        en_long = 1'b1;
        en_short = 1'b1;
        i_offset_en = 1'b1;
        repeat (cycles) @(negedge clk);
        chk(dith_i == 1'b0, "R1", "dith_i in reset", int'(dith_i), 0);
        chk(dith_q == 1'b0, "R1", "dith_q in reset", int'(dith_q), 0);
        chk(dith_valid == 1'b0, "R1", "dith_valid in reset", int'(dith_valid), 0);
        m_long  = '1;
        m_short = '1;
    endtask

    // Monitor: compares the outputs one time step after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(dith_q == e.eq, e.tag, "dith_q", int'(dith_q), int'(e.eq));
                chk(dith_i == e.ei, e.tag, "dith_i", int'(dith_i), int'(e.ei));
                chk(dith_valid == e.ev, e.tag, "dith_valid", int'(dith_valid), int'(e.ev));
                if (e.tag == "R7" && dith_i != dith_q) ofs_diffs++;
                if (e.tag == "R3") begin
                    if (short_idx < CAP) cap_first[short_idx] = dith_q;
                    else if (short_idx >= SHORT_PERIOD && short_idx < SHORT_PERIOD + CAP)
                        chk(dith_q == cap_first[short_idx - SHORT_PERIOD], "R3",
                            "period repeat bit", int'(dith_q),
                            int'(cap_first[short_idx - SHORT_PERIOD]));
                    short_idx++;
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset(4);                                   // R1
        repeat (6) drive(1'b0, 1'b0, 1'b1, "R8");      // idle: zeros, valid low
        drive(1'b1, 1'b0, 1'b0, "R1");                 // first step from all ones
        repeat (250) drive(1'b1, 1'b0, 1'b0, "R2");    // long alone
        repeat (SHORT_PERIOD + CAP + 2) drive(1'b0, 1'b1, 1'b0, "R3");
        repeat (300) drive(1'b1, 1'b1, 1'b0, "R5");    // both, XOR
        repeat (300) drive(1'b1, 1'b1, 1'b0, "R6");
        repeat (400) drive(1'b1, 1'b1, 1'b1, "R7");
        repeat (100) drive(1'b0, 1'b1, 1'b1, "R7");
        for (int k = 0; k < 600; k++)                  // irregular enables
            drive(k % 3 != 0, (k % 5) < 2, k[3], "R4");
        repeat (4) drive(1'b0, 1'b0, 1'b1, "R8");
        for (int k = 0; k < 50; k++)
            drive(k[0], ~k[0], 1'b0, "R9");
        do_reset(3);                                   // mid-run reset
        drive(1'b0, 1'b1, 1'b1, "R1");
        repeat (60) drive(1'b1, 1'b1, 1'b1, "R1");
        @(negedge clk);
        @(negedge clk);
        chk(sb_q.size() == 0, "R9", "pending items", sb_q.size(), 0);
        chk(short_idx >= SHORT_PERIOD + CAP, "R3", "period samples", short_idx,
            SHORT_PERIOD + CAP);
        chk(ofs_diffs > 0, "R7", "I/Q differences seen", ofs_diffs, 1);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule